// File: doc/BRIEF.md
# LPC TPM-Cycle Target Engine

This block is the bus-facing half of a peripheral that sits on a Low Pin Count bus. It samples the four shared address/data lines and the active-low frame strobe on every rising edge of the bus clock. It recognises TPM-type read and write cycles and collects their 16-bit address and, for writes, one data byte. Each decoded access goes to an internal register port as a locality, a register offset, a direction flag and write data.

The register port answers with an accept, which carries read data for reads, or with a reject. It may answer in the same cycle as the request or any number of cycles later. While the answer is outstanding, the block stretches the bus cycle with long-wait SYNC nibbles. An accepted access is closed with SYNC OK, followed by read data where there is any, and the bus is then handed back. A rejected access gets no SYNC at all, so the host master-aborts it. A write is committed to the register side only through a strobe that fires when SYNC OK is driven.

Every other cycle type is ignored without any response. A new frame strobe ends whatever cycle is in progress, and the active-low reset clears the engine in any phase.

Top module: `lpc_tpm_target`

## Requirements
- R1: A cycle that opens with start nibble 0101 (sampled while `frame_n` is low) and has direction nibble 0000 is a read. The four address nibbles that follow arrive most significant first. In the first turnaround clock after the last address nibble, `reg_req` is high for exactly one clock with `reg_we`=0, `reg_loc` = address bits [15:12] and `reg_ofs` = address bits [11:0].
- R2: Direction nibble 0010 marks a write. Two data nibbles follow the address, low nibble first. `reg_req` is then high for one clock, in the first turnaround clock after the second data nibble, with `reg_we`=1 and `reg_wdata` holding the assembled byte.
- R3: A start nibble other than 0101, or a direction nibble other than 0000 or 0010, produces no request and leaves `lad_oe` low.
- R4: The target does not drive LAD during the host phases or during the two host turnaround clocks. After its last nibble (SYNC OK for a write, the high data nibble for a read), it drives 1111 for one clock and then releases the bus.
- R5: The target never drives an error SYNC. If the port answers L cycles after `reg_req` (L=0 meaning the same clock), the SYNC phase starts with max(0, L-1) long-wait nibbles 0110 and ends with SYNC OK 0000.
- R6: For an accepted read, the two clocks after SYNC OK carry `reg_rdata`, low nibble first.
- R7: When the port answers with `reg_abort`, the target drives nothing from the SYNC slot on, so any long-wait nibbles already driven are followed by a released bus, and `reg_wstb` never fires.
- R8: `reg_wstb` is high for exactly one clock per accepted write. That clock is the one in which SYNC OK is driven, and the strobe never fires for reads.
- R9: If `frame_n` is low at a clock edge, any cycle in progress ends: LAD is released from the next clock on, a late answer from the port is ignored, and a 0101 nibble in that clock starts a new cycle.
- R10: While `rst_n` is low, and after it rises until a new cycle arrives, `lad_oe`, `reg_req` and `reg_wstb` are low, whatever phase the engine was in when reset arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, unconditional |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared address/data lines |
| lad_out | output | 4 | Nibble the target drives when enabled |
| lad_oe | output | 1 | Output enable for the shared lines |
| reg_req | output | 1 | One-clock request to the register port |
| reg_we | output | 1 | Direction of the current access, 1 = write |
| reg_loc | output | 4 | Locality, address bits [15:12] |
| reg_ofs | output | 12 | Register offset, address bits [11:0] |
| reg_wdata | output | 8 | Write byte of the current access |
| reg_wstb | output | 1 | Commit strobe for an accepted write |
| reg_ack | input | 1 | Port accepts the pending access |
| reg_abort | input | 1 | Port rejects the pending access |
| reg_rdata | input | 8 | Read byte, taken while `reg_ack` is high |

## Verification
The bench drives the bus on falling edges and observes it on the falling edge that follows each rising edge. In a read, the request is due in the sixth observation after the start nibble and the first SYNC nibble in the eighth. A write adds two clocks for its data nibbles. The responder answers a chosen number of falling edges after it sees the request, and the bench expects max(0, L-1) long-wait nibbles before SYNC OK or the release. Read data, the 1111 turnaround nibble and the released bus are each checked in the one observation in which they are due.

// File: rtl/lpc_tpm_pkg.sv
package lpc_tpm_pkg;

  localparam logic [3:0] NIB_START     = 4'b0101;
  localparam logic [3:0] NIB_DIR_RD    = 4'b0000;
  localparam logic [3:0] NIB_DIR_WR    = 4'b0010;
  localparam logic [3:0] NIB_SYNC_OK   = 4'b0000;
  localparam logic [3:0] NIB_LONG_WAIT = 4'b0110;
  localparam logic [3:0] NIB_TAR       = 4'b1111;
  localparam int         TAR_CLKS      = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WDATA,
    ST_TAR_IN,
    ST_SYNC,
    ST_RDATA,
    ST_TAR_OUT
  } lpc_st_e;

  // direction nibble belongs to a TPM-type access
  function automatic logic f_is_tpm_dir(input logic [3:0] nib);
    return (nib == NIB_DIR_RD) || (nib == NIB_DIR_WR);
  endfunction

  function automatic logic f_dir_is_write(input logic [3:0] nib);
    return nib == NIB_DIR_WR;
  endfunction

  // nibble idx of a data word, idx 0 = least significant
  function automatic logic [3:0] f_nib_sel(input logic [63:0] data, input int idx);
    return data[idx*4 +: 4];
  endfunction

  // number of long-wait nibbles for a response latency (cycles after request)
  function automatic int f_wait_nibbles(input int latency);
    return (latency > 1) ? latency - 1 : 0;
  endfunction

endpackage

// File: rtl/lpc_tpm_seq.sv
module lpc_tpm_seq
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_NIB = 4,
  parameter int DATA_NIB = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [3:0]       lad_in,
  input  logic             resp_ok,
  input  logic             resp_abort,
  output lpc_st_e          st,
  output logic [CNT_W-1:0] cnt,
  output logic             wr,
  output logic             ev_addr,
  output logic             ev_data,
  output logic             ev_issue,
  output logic             ev_sync_ok
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIB - 1);
  localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(TAR_CLKS - 1);

  lpc_st_e          st_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wr_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    wr_nxt  = wr;
    if (!frame_n) begin
      // frame strobe ends any cycle; a start nibble opens a new one
      st_nxt  = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      cnt_nxt = '0;
    end else begin
      unique case (st)
        ST_IDLE: st_nxt = ST_IDLE;
        ST_CTYPE: begin
          cnt_nxt = '0;
          if (f_is_tpm_dir(lad_in)) begin
            st_nxt = ST_ADDR;
            wr_nxt = f_dir_is_write(lad_in);
          end else begin
            st_nxt = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (cnt == ADDR_LAST) begin
            st_nxt  = wr ? ST_WDATA : ST_TAR_IN;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_WDATA: begin
          if (cnt == DATA_LAST) begin
            st_nxt  = ST_TAR_IN;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_TAR_IN: begin
          if (cnt == TAR_LAST) begin
            st_nxt  = ST_SYNC;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (resp_abort) begin
            st_nxt = ST_IDLE;
          end else if (resp_ok) begin
            st_nxt  = wr ? ST_TAR_OUT : ST_RDATA;
            cnt_nxt = '0;
          end
        end
        ST_RDATA: begin
          if (cnt == DATA_LAST) begin
            st_nxt  = ST_TAR_OUT;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_TAR_OUT: begin
          if (cnt == TAR_LAST) begin
            st_nxt  = ST_IDLE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      wr  <= 1'b0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
      wr  <= wr_nxt;
    end
  end

  assign ev_addr    = frame_n && (st == ST_ADDR);
  assign ev_data    = frame_n && (st == ST_WDATA);
  assign ev_issue   = frame_n && (st == ST_TAR_IN) && (cnt == '0);
  assign ev_sync_ok = (st == ST_SYNC) && resp_ok;

endmodule

// File: rtl/lpc_tpm_capture.sv
module lpc_tpm_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic              ev_issue,
  input  logic              reg_ack,
  input  logic              reg_abort,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              resp_ok,
  output logic              resp_abort
);

  logic pending;
  logic hit;

  assign hit = reg_ack || reg_abort;

  // address arrives most significant nibble first, data least significant first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (ev_addr) addr_q  <= {addr_q[ADDR_W-5:0], lad_in};
      if (ev_data) wdata_q <= {lad_in, wdata_q[DATA_W-1:4]};
    end
  end

  // answer latch: open from the request clock until an answer or a new frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      resp_ok    <= 1'b0;
      resp_abort <= 1'b0;
      rdata_q    <= '0;
    end else if (!frame_n) begin
      pending    <= 1'b0;
      resp_ok    <= 1'b0;
      resp_abort <= 1'b0;
    end else if (ev_issue || (pending && hit)) begin
      pending    <= !hit;
      resp_ok    <= reg_ack;
      resp_abort <= reg_abort && !reg_ack;
      if (reg_ack) rdata_q <= reg_rdata;
    end
  end

endmodule

// File: rtl/lpc_tpm_drive.sv
module lpc_tpm_drive
  import lpc_tpm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  lpc_st_e           st,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              resp_ok,
  input  logic              resp_abort,
  input  logic [DATA_W-1:0] rdata_q,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              sync_drive,
  output logic              tar_drive
);

  always_comb begin
    lad_out    = 4'b0000;
    lad_oe     = 1'b0;
    sync_drive = 1'b0;
    tar_drive  = 1'b0;
    unique case (st)
      ST_SYNC: begin
        if (!resp_abort) begin
          lad_oe     = 1'b1;
          sync_drive = 1'b1;
          lad_out    = resp_ok ? NIB_SYNC_OK : NIB_LONG_WAIT;
        end
      end
      ST_RDATA: begin
        lad_oe  = 1'b1;
        lad_out = f_nib_sel(64'(rdata_q), int'(cnt));
      end
      ST_TAR_OUT: begin
        if (cnt == '0) begin
          lad_oe    = 1'b1;
          tar_drive = 1'b1;
          lad_out   = NIB_TAR;
        end
      end
      default: begin
        lad_oe = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lpc_tpm_target.sv
module lpc_tpm_target
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LOC_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_n,
  input  logic [3:0]                lad_in,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  output logic                      reg_req,
  output logic                      reg_we,
  output logic [LOC_W-1:0]          reg_loc,
  output logic [ADDR_W-LOC_W-1:0]   reg_ofs,
  output logic [DATA_W-1:0]         reg_wdata,
  output logic                      reg_wstb,
  input  logic                      reg_ack,
  input  logic                      reg_abort,
  input  logic [DATA_W-1:0]         reg_rdata
);

  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int DATA_NIB = DATA_W / 4;
  localparam int OFS_W    = ADDR_W - LOC_W;
  localparam int MAX_NIB  = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
  localparam int CNT_W    = (MAX_NIB <= 2) ? 1 : $clog2(MAX_NIB);

  lpc_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic              wr;
  logic              ev_addr;
  logic              ev_data;
  logic              ev_issue;
  logic              ev_sync_ok;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              resp_ok;
  logic              resp_abort;
  logic              sync_drive;
  logic              tar_drive;

  lpc_tpm_seq #(
    .ADDR_NIB (ADDR_NIB),
    .DATA_NIB (DATA_NIB),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .lad_in     (lad_in),
    .resp_ok    (resp_ok),
    .resp_abort (resp_abort),
    .st         (st),
    .cnt        (cnt),
    .wr         (wr),
    .ev_addr    (ev_addr),
    .ev_data    (ev_data),
    .ev_issue   (ev_issue),
    .ev_sync_ok (ev_sync_ok)
  );

  lpc_tpm_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .lad_in     (lad_in),
    .ev_addr    (ev_addr),
    .ev_data    (ev_data),
    .ev_issue   (ev_issue),
    .reg_ack    (reg_ack),
    .reg_abort  (reg_abort),
    .reg_rdata  (reg_rdata),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .rdata_q    (rdata_q),
    .resp_ok    (resp_ok),
    .resp_abort (resp_abort)
  );

  lpc_tpm_drive #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_drv (
    .st         (st),
    .cnt        (cnt),
    .resp_ok    (resp_ok),
    .resp_abort (resp_abort),
    .rdata_q    (rdata_q),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .sync_drive (sync_drive),
    .tar_drive  (tar_drive)
  );

  assign reg_req   = ev_issue;
  assign reg_we    = wr;
  assign reg_loc   = addr_q[ADDR_W-1 -: LOC_W];
  assign reg_ofs   = addr_q[OFS_W-1:0];
  assign reg_wdata = wdata_q;
  assign reg_wstb  = ev_sync_ok && wr;

endmodule

// File: rtl/lpc_tpm_target_chk.sv
module lpc_tpm_target_chk
  import lpc_tpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       lad_oe,
  input logic [3:0] lad_out,
  input logic       reg_req,
  input logic       reg_we,
  input logic       reg_wstb,
  input logic       sync_drive,
  input logic       tar_drive,
  input logic       resp_ok,
  input logic       resp_abort
);

  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);

  a_r4_host_tar_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !lad_oe);

  a_r4_host_tar_quiet_second: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !lad_oe);

  a_r4_release_after_tar: assert property (@(posedge clk) disable iff (!rst_n)
    tar_drive |=> !lad_oe);

  a_r5_no_error_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_drive |-> (lad_out == NIB_SYNC_OK || lad_out == NIB_LONG_WAIT));

  a_r7_answer_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_ok && resp_abort));

  a_r7_abort_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort |-> !reg_wstb);

  a_r8_strobe_with_sync_ok: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wstb |-> (reg_we && lad_oe && lad_out == NIB_SYNC_OK));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wstb |=> !reg_wstb);

  a_r9_frame_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lad_oe && !reg_req && !reg_wstb));

endmodule

bind lpc_tpm_target lpc_tpm_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .lad_oe     (lad_oe),
  .lad_out    (lad_out),
  .reg_req    (reg_req),
  .reg_we     (reg_we),
  .reg_wstb   (reg_wstb),
  .sync_drive (sync_drive),
  .tar_drive  (tar_drive),
  .resp_ok    (resp_ok),
  .resp_abort (resp_abort)
);

// File: tb/sim_lpc_tpm_target.sv
module sim_lpc_tpm_target;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int LW = 4;
  localparam int OW = AW - LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic [3:0]    lad_in = 4'hF;
  logic [3:0]    lad_out;
  logic          lad_oe;
  logic          reg_req;
  logic          reg_we;
  logic [LW-1:0] reg_loc;
  logic [OW-1:0] reg_ofs;
  logic [DW-1:0] reg_wdata;
  logic          reg_wstb;
  logic          reg_ack = 1'b0;
  logic          reg_abort = 1'b0;
  logic [DW-1:0] reg_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int rsp_lat = 0;
  bit rsp_abt = 1'b0;
  int rsp_cnt = -1;
  int req_seen = 0;
  int wstb_seen = 0;

  always #2 clk = ~clk;

  lpc_tpm_target u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_loc   (reg_loc),
    .reg_ofs   (reg_ofs),
    .reg_wdata (reg_wdata),
    .reg_wstb  (reg_wstb),
    .reg_ack   (reg_ack),
    .reg_abort (reg_abort),
    .reg_rdata (reg_rdata)
  );

  // register-port model: answers rsp_lat falling edges after it sees a request
  always @(negedge clk) begin
    reg_ack   = 1'b0;
    reg_abort = 1'b0;
    if (rst_n && reg_req) begin
      rsp_cnt = rsp_lat;
      req_seen++;
    end
    if (rsp_cnt == 0) begin
      if (rsp_abt) reg_abort = 1'b1;
      else         reg_ack   = 1'b1;
      rsp_cnt = -1;
    end else if (rsp_cnt > 0) begin
      rsp_cnt--;
    end
    if (reg_wstb) wstb_seen++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    lad_in  = n;
  endtask

  task automatic send_hdr(input logic [3:0] start, input logic [3:0] dir, input logic [15:0] addr);
    drive(1'b0, start);
    drive(1'b1, dir);
    for (int i = 0; i < 4; i++) drive(1'b1, addr[15-4*i -: 4]);
  endtask

  task automatic quiet_for(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!lad_oe && !reg_req && !reg_wstb, tag, {lad_oe, reg_req, reg_wstb}, 0);
    end
  endtask

  // full TPM cycle with register-port latency lat; abt selects rejection
  task automatic run_xfer(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                          input int lat, input bit abt, input logic [7:0] rd);
    int waits;
    int exp_w;
    rsp_lat   = lat;
    rsp_abt   = abt;
    reg_rdata = rd;
    send_hdr(4'b0101, wr ? 4'b0010 : 4'b0000, addr);
    if (wr) begin
      drive(1'b1, wd[3:0]);
      drive(1'b1, wd[7:4]);
    end
    drive(1'b1, 4'hF);
    chk(reg_req == 1'b1, wr ? "R2 request pulse" : "R1 request pulse", reg_req, 1);
    chk({reg_loc, reg_ofs} == addr, "R1 locality/offset", {reg_loc, reg_ofs}, addr);
    chk(reg_we == wr, wr ? "R2 direction" : "R1 direction", reg_we, wr);
    if (wr) chk(reg_wdata == wd, "R2 write byte", reg_wdata, wd);
    chk(!lad_oe, "R4 host turnaround 1", lad_oe, 0);
    drive(1'b1, 4'hF);
    chk(!lad_oe && !reg_req, "R4 host turnaround 2", {lad_oe, reg_req}, 0);
    exp_w = (lat > 1) ? lat - 1 : 0;
    waits = 0;
    @(negedge clk);
    while (lad_oe && lad_out == 4'b0110 && waits < 64) begin
      waits++;
      @(negedge clk);
    end
    chk(waits == exp_w, "R5 long-wait count", waits, exp_w);
    if (abt) begin
      chk(!lad_oe, "R7 no SYNC on abort", lad_oe, 0);
      chk(!reg_wstb, "R7 no commit on abort", reg_wstb, 0);
      quiet_for(3, "R7 bus stays released");
    end else begin
      chk(lad_oe && lad_out == 4'b0000, "R5 SYNC OK", {lad_oe, lad_out}, 5'h10);
      chk(reg_wstb == wr, "R8 commit strobe with SYNC OK", reg_wstb, wr);
      if (!wr) begin
        @(negedge clk);
        chk(lad_oe && lad_out == rd[3:0], "R6 low data nibble", {lad_oe, lad_out}, {1'b1, rd[3:0]});
        @(negedge clk);
        chk(lad_oe && lad_out == rd[7:4], "R6 high data nibble", {lad_oe, lad_out}, {1'b1, rd[7:4]});
      end
      @(negedge clk);
      chk(lad_oe && lad_out == 4'hF && !reg_wstb, "R4 target turnaround 1111",
          {lad_oe, lad_out}, 5'h1F);
      @(negedge clk);
      chk(!lad_oe, "R4 bus released", lad_oe, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL WATCHDOG run did not finish act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0;
    int r0;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!lad_oe && !reg_req && !reg_wstb, "R10 outputs in reset", {lad_oe, reg_req, reg_wstb}, 0);
    rst_n = 1'b1;
    quiet_for(2, "R10 quiet after reset");

    // R1 R5 R6: read, immediate answer; slower answer with waits
    run_xfer(1'b0, 16'h1F3C, 8'h00, 0, 1'b0, 8'hA5);
    run_xfer(1'b0, 16'h4018, 8'h00, 4, 1'b0, 8'h3E);
    // R2 R8: writes
    w0 = wstb_seen;
    run_xfer(1'b1, 16'h2ABC, 8'h3C, 1, 1'b0, 8'h00);
    run_xfer(1'b1, 16'h0F00, 8'hD2, 3, 1'b0, 8'h00);
    @(negedge clk);
    chk(wstb_seen - w0 == 2, "R8 one strobe per accepted write", wstb_seen - w0, 2);

    // R7: rejected write after a wait, rejected read at once
    w0 = wstb_seen;
    run_xfer(1'b1, 16'h3004, 8'h77, 2, 1'b1, 8'h00);
    run_xfer(1'b0, 16'h0024, 8'h00, 0, 1'b1, 8'h11);
    @(negedge clk);
    chk(wstb_seen == w0, "R7 no strobe for rejected accesses", wstb_seen - w0, 0);

    // R3: foreign cycle types are ignored
    r0 = req_seen;
    send_hdr(4'b0000, 4'b0000, 16'h1234);
    quiet_for(6, "R3 non-TPM start ignored");
    send_hdr(4'b0101, 4'b0100, 16'h0000);
    quiet_for(6, "R3 unknown direction ignored");
    send_hdr(4'b0101, 4'b0011, 16'hFFFF);
    quiet_for(6, "R3 odd direction ignored");
    chk(req_seen == r0, "R3 no request issued", req_seen - r0, 0);

    // R9: frame strobe mid-address restarts the cycle
    r0 = req_seen;
    drive(1'b0, 4'b0101);
    drive(1'b1, 4'b0000);
    drive(1'b1, 4'h1);
    drive(1'b1, 4'h2);
    run_xfer(1'b0, 16'h0ABC, 8'h00, 0, 1'b0, 8'h69);
    chk(req_seen - r0 == 1, "R9 only the restarted cycle requests", req_seen - r0, 1);

    // R9: frame strobe during long-wait
    w0 = wstb_seen;
    rsp_lat = 8;
    rsp_abt = 1'b0;
    send_hdr(4'b0101, 4'b0010, 16'h1100);
    drive(1'b1, 4'h5);
    drive(1'b1, 4'hA);
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    @(negedge clk);
    chk(lad_oe && lad_out == 4'b0110, "R5 long-wait before frame abort", {lad_oe, lad_out}, 5'h16);
    drive(1'b0, 4'hF);
    chk(lad_oe && lad_out == 4'b0110, "R5 still waiting", {lad_oe, lad_out}, 5'h16);
    drive(1'b1, 4'hF);
    chk(!lad_oe, "R9 bus released after frame", lad_oe, 0);
    quiet_for(12, "R9 late answer ignored");
    chk(wstb_seen == w0, "R9 no commit after frame abort", wstb_seen - w0, 0);
    run_xfer(1'b0, 16'h2200, 8'h00, 1, 1'b0, 8'hC3);

    // R10: reset in the middle of a cycle
    rsp_lat = 20;
    send_hdr(4'b0101, 4'b0000, 16'h0100);
    drive(1'b1, 4'hF);
    @(negedge clk);
    rst_n = 1'b0;
    quiet_for(3, "R10 quiet during reset");
    rst_n = 1'b1;
    quiet_for(25, "R10 quiet after mid-cycle reset");
    run_xfer(1'b0, 16'h3333, 8'h00, 2, 1'b0, 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule